// File: doc/BRIEF.md
# Flash Read-Path Data Selector

This block forms the read half of a NOR flash model. A separate command sequencer decides which command mode the device is in and presents that mode on an input. For every read request the block chooses the data source for that mode: the storage array, the identification words, the status register, or the query table. It returns the chosen word one clock later. The storage array lives outside the block. The four bytes that start at the read address come in on `arr_bytes`, and the block packs them into 8-, 16- or 32-bit results in the byte order set by a parameter.

The block owns the status register. The sequencer signals program completion, erase start and operation completion with single-cycle pulses, and the block updates the register from them. Each status read while an operation is active flips bit 6, so software can poll for completion by watching for the toggle to stop. The identification values and the query table come from parameters. The table's device-size and sector-geometry fields are derived from the size parameters.

Top module: `flrd_read_mux`

## Requirements
- R1: While reset is asserted, `rd_valid` is 0 and `rd_data` is 0. The status register resets to 8'h00.
- R2: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high. `rd_data` is registered and holds the word chosen in the request cycle.
- R3: In mode 0 (read), mode 1 (erase setup), and the unused mode values 5, 6 and 7, the result is array data. Size code 0 returns byte 0 (`arr_bytes[7:0]`). Size code 1 returns two bytes and size codes 2 and 3 return four bytes, with the lowest address in the least significant byte when `BIG_ENDIAN`=0 and in the most significant byte when it is 1. Unused upper bits are zero.
- R4: The table offset is the low address byte shifted right by 0, 1 or 2 for `BUS_BYTES` 1, 2 or 4.
- R5: In mode 2 (autoselect), offset 0 returns `MAN_ID`, offset 1 returns `DEV_ID` and offset 2 returns 0, each zero-extended.
- R6: In mode 2, offset 8'h0E returns `EXT_ID0` and offset 8'h0F returns `EXT_ID1`. If that ID is all ones, or if the offset is any other value, the result is array data as in R3.
- R7: In mode 3 (operation active), the result is the status register zero-extended. Each such read inverts status bit 6 after the value is returned.
- R8: An `erase_start` pulse clears the status register to 8'h00. A `prog_load` pulse sets it to {~`prog_d7`, 7'h7F}. An `op_done` pulse inverts bit 7. When pulses coincide, the priority is erase_start, then prog_load, then op_done, then the toggle from a read.
- R9: In mode 4 (query), the result is the table byte at the offset. Offsets of 8'h52 and above return 0.
- R10: The table holds 8'h51, 8'h52, 8'h59 at offsets 8'h10 to 8'h12. Offset 8'h27 holds `SECTOR_LOG2`+`SECTOR_CNT_LOG2`. Offset 8'h2D holds the low byte of the sector count minus one, and offset 8'h30 holds bits 23:16 of the sector size.
- R11: Reads in any mode other than 3 leave the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Command mode from the sequencer (0 read, 1 erase setup, 2 autoselect, 3 operation active, 4 query) |
| rd_en | input | 1 | Read request |
| rd_addr_lo | input | 8 | Low byte of the read address |
| rd_size | input | 2 | Access size code (0 byte, 1 half, 2 or 3 word) |
| arr_bytes | input | 32 | Array bytes at address +0 to +3, address +0 in bits 7:0 |
| prog_load | input | 1 | Program finished, load status from data bit 7 |
| prog_d7 | input | 1 | Bit 7 of the programmed data |
| erase_start | input | 1 | Erase started, clear status |
| op_done | input | 1 | Operation finished, invert status bit 7 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
Random reads cover every mode value, every size code and a range of addresses. Autoselect offsets are drawn with a bias towards 0, 1, 2, 8'h0E and 8'h0F, so each identification slot and the fallback to array data are hit. Two instances run side by side: one 16-bit little-endian and one 32-bit big-endian. Their results differ only in byte packing and offset scaling, which separates the lane-order logic from the offset shift. Status pulses are mixed in between runs of status reads, so the bench's status model can tell a missing toggle, a wrong bit-7 load or a wrong priority from correct behaviour. Directed reads then check the query signature, the device-size field, the table tail and the all-ones identification fallback.

// File: rtl/flrd_pkg.sv
package flrd_pkg;

  localparam logic [2:0] MODE_READ        = 3'd0;
  localparam logic [2:0] MODE_ERASE_SETUP = 3'd1;
  localparam logic [2:0] MODE_AUTOSEL     = 3'd2;
  localparam logic [2:0] MODE_BUSY        = 3'd3;
  localparam logic [2:0] MODE_QUERY       = 3'd4;

  localparam logic [7:0] QUERY_LEN = 8'h52;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_ID     = 2'd1,
    SRC_STATUS = 2'd2,
    SRC_QUERY  = 2'd3
  } flrd_src_e;

  // shift amount that converts a byte offset to a bus-word offset
  function automatic int unsigned off_shift(input int unsigned bus_bytes);
    if (bus_bytes >= 4) return 2;
    else if (bus_bytes == 2) return 1;
    else return 0;
  endfunction

  // pack bytes with the lowest address in the least significant lane
  function automatic logic [31:0] pack_le(input logic [31:0] b, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'h0, b[7:0]};
      2'd1:    return {16'h0, b[15:8], b[7:0]};
      default: return b;
    endcase
  endfunction

  // pack bytes with the lowest address in the most significant lane
  function automatic logic [31:0] pack_be(input logic [31:0] b, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'h0, b[7:0]};
      2'd1:    return {16'h0, b[7:0], b[15:8]};
      default: return {b[7:0], b[15:8], b[23:16], b[31:24]};
    endcase
  endfunction

endpackage

// File: rtl/flrd_array_fmt.sv
module flrd_array_fmt #(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [31:0] arr_bytes,
  input  logic [1:0]  rd_size,
  output logic [31:0] arr_word
);
  import flrd_pkg::*;

  generate
    if (BIG_ENDIAN) begin : g_be
      assign arr_word = pack_be(arr_bytes, rd_size);
    end else begin : g_le
      assign arr_word = pack_le(arr_bytes, rd_size);
    end
  endgenerate

endmodule

// File: rtl/flrd_id_sel.sv
module flrd_id_sel #(
  parameter int unsigned    ID_W    = 16,
  parameter logic [ID_W-1:0] MAN_ID  = '0,
  parameter logic [ID_W-1:0] DEV_ID  = '0,
  parameter logic [ID_W-1:0] EXT_ID0 = '1,
  parameter logic [ID_W-1:0] EXT_ID1 = '1
) (
  input  logic [7:0]  word_off,
  output logic        id_hit,
  output logic [31:0] id_word
);
  localparam logic [ID_W-1:0] ALL_ONES = {ID_W{1'b1}};
  localparam bit EXT0_USED = (EXT_ID0 != ALL_ONES);
  localparam bit EXT1_USED = (EXT_ID1 != ALL_ONES);

  always_comb begin
    id_hit  = 1'b0;
    id_word = 32'h0;
    case (word_off)
      8'h00: begin id_hit = 1'b1; id_word = 32'(MAN_ID); end
      8'h01: begin id_hit = 1'b1; id_word = 32'(DEV_ID); end
      8'h02: begin id_hit = 1'b1; id_word = 32'h0;       end
      8'h0E: begin id_hit = EXT0_USED; id_word = 32'(EXT_ID0); end
      8'h0F: begin id_hit = EXT1_USED; id_word = 32'(EXT_ID1); end
      default: ;
    endcase
  end

endmodule

// File: rtl/flrd_query_rom.sv
module flrd_query_rom #(
  parameter int unsigned SECTOR_LOG2     = 16,
  parameter int unsigned SECTOR_CNT_LOG2 = 6
) (
  input  logic [7:0] word_off,
  output logic [7:0] q_byte
);
  import flrd_pkg::*;

  localparam logic [7:0]  SIZE_LOG2  = 8'(SECTOR_LOG2 + SECTOR_CNT_LOG2);
  localparam logic [31:0] SECT_LAST  = 32'((64'd1 << SECTOR_CNT_LOG2) - 64'd1);
  localparam logic [31:0] SECT_BYTES = 32'(64'd1 << SECTOR_LOG2);

  function automatic logic [7:0] table_byte(input logic [7:0] o);
    case (o)
      8'h10: return 8'h51;            // signature letters
      8'h11: return 8'h52;
      8'h12: return 8'h59;
      8'h13: return 8'h02;            // command set id
      8'h15: return 8'h31;            // extended table pointer
      8'h1B: return 8'h27;            // supply window
      8'h1C: return 8'h36;
      8'h1F: return 8'h07;
      8'h21: return 8'h09;            // erase timing hints
      8'h22: return 8'h0C;
      8'h23: return 8'h01;
      8'h25: return 8'h0A;
      8'h26: return 8'h0D;
      8'h27: return SIZE_LOG2;        // device size as a power of two
      8'h28: return 8'h02;            // interface width code
      8'h2C: return 8'h01;            // one uniform erase region
      8'h2D: return SECT_LAST[7:0];
      8'h2E: return SECT_LAST[15:8];
      8'h2F: return SECT_BYTES[15:8];
      8'h30: return SECT_BYTES[23:16];
      8'h31: return 8'h50;            // extended signature
      8'h32: return 8'h52;
      8'h33: return 8'h49;
      8'h34: return 8'h31;
      8'h35: return 8'h30;
      default: return 8'h00;
    endcase
  endfunction

  assign q_byte = (word_off < QUERY_LEN) ? table_byte(word_off) : 8'h00;

endmodule

// File: rtl/flrd_status_reg.sv
module flrd_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy_read,
  input  logic       prog_load,
  input  logic       prog_d7,
  input  logic       erase_start,
  input  logic       op_done,
  output logic [7:0] status_q
);
  logic any_event;
  assign any_event = erase_start | prog_load | op_done;

  always_ff @(posedge clk) begin
    if (!rst_n)           status_q <= 8'h00;
    else if (erase_start) status_q <= 8'h00;
    else if (prog_load)   status_q <= {~prog_d7, 7'h7F};
    else if (op_done)     status_q <= status_q ^ 8'h80;
    else if (busy_read)   status_q <= status_q ^ 8'h40;
  end

  a_r8_erase_clear: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> status_q == 8'h00);

  a_r8_prog_load: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_load && !erase_start) |=> status_q == {~$past(prog_d7), 7'h7F});

  a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_read && !any_event) |=> status_q == ($past(status_q) ^ 8'h40));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_read && !any_event) |=> $stable(status_q));

endmodule

// File: rtl/flrd_read_mux.sv
module flrd_read_mux #(
  parameter int unsigned     BUS_BYTES       = 2,
  parameter bit              BIG_ENDIAN      = 1'b0,
  parameter int unsigned     ID_W            = 16,
  parameter logic [ID_W-1:0] MAN_ID          = 16'h0001,
  parameter logic [ID_W-1:0] DEV_ID          = 16'h227E,
  parameter logic [ID_W-1:0] EXT_ID0         = 16'h2210,
  parameter logic [ID_W-1:0] EXT_ID1         = 16'hFFFF,
  parameter int unsigned     SECTOR_LOG2     = 16,
  parameter int unsigned     SECTOR_CNT_LOG2 = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mode,
  input  logic        rd_en,
  input  logic [7:0]  rd_addr_lo,
  input  logic [1:0]  rd_size,
  input  logic [31:0] arr_bytes,
  input  logic        prog_load,
  input  logic        prog_d7,
  input  logic        erase_start,
  input  logic        op_done,
  output logic        rd_valid,
  output logic [31:0] rd_data
);
  import flrd_pkg::*;

  localparam int unsigned SHIFT = off_shift(BUS_BYTES);

  logic [7:0]  word_off;
  logic [31:0] arr_word;
  logic        id_hit;
  logic [31:0] id_word;
  logic [7:0]  q_byte;
  logic [7:0]  status_val;
  logic        busy_read;
  flrd_src_e   src_sel;
  logic [31:0] sel_word;

  assign word_off  = rd_addr_lo >> SHIFT;
  assign busy_read = rd_en && (mode == MODE_BUSY);

  flrd_array_fmt #(.BIG_ENDIAN(BIG_ENDIAN)) u_fmt (
    .arr_bytes (arr_bytes),
    .rd_size   (rd_size),
    .arr_word  (arr_word)
  );

  flrd_id_sel #(
    .ID_W(ID_W), .MAN_ID(MAN_ID), .DEV_ID(DEV_ID),
    .EXT_ID0(EXT_ID0), .EXT_ID1(EXT_ID1)
  ) u_id (
    .word_off (word_off),
    .id_hit   (id_hit),
    .id_word  (id_word)
  );

  flrd_query_rom #(
    .SECTOR_LOG2(SECTOR_LOG2), .SECTOR_CNT_LOG2(SECTOR_CNT_LOG2)
  ) u_query (
    .word_off (word_off),
    .q_byte   (q_byte)
  );

  flrd_status_reg u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_read   (busy_read),
    .prog_load   (prog_load),
    .prog_d7     (prog_d7),
    .erase_start (erase_start),
    .op_done     (op_done),
    .status_q    (status_val)
  );

  // source choice; unlisted mode values read the array
  always_comb begin
    case (mode)
      MODE_AUTOSEL: src_sel = id_hit ? SRC_ID : SRC_ARRAY;
      MODE_BUSY:    src_sel = SRC_STATUS;
      MODE_QUERY:   src_sel = SRC_QUERY;
      default:      src_sel = SRC_ARRAY;
    endcase
  end

  always_comb begin
    case (src_sel)
      SRC_ID:     sel_word = id_word;
      SRC_STATUS: sel_word = {24'h0, status_val};
      SRC_QUERY:  sel_word = {24'h0, q_byte};
      default:    sel_word = arr_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 32'h0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel_word;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  a_r7_status_out: assert property (@(posedge clk) disable iff (!rst_n)
    busy_read |=> rd_data == {24'h0, $past(status_val)});

  a_r5_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == MODE_AUTOSEL && word_off == 8'h02) |=> rd_data == 32'h0);

  a_r9_query_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == MODE_QUERY && word_off >= QUERY_LEN) |=> rd_data == 32'h0);

endmodule

// File: tb/flrd_read_mux_tb.sv
module flrd_read_mux_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        rd_en = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [1:0]  rd_size = 2'd0;
  logic        prog_load = 1'b0, prog_d7 = 1'b0, erase_start = 1'b0, op_done = 1'b0;
  logic [31:0] arr_bytes;
  logic        v_le, v_be;
  logic [31:0] d_le, d_be;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_st = 8'h00;

  always #10 clk = ~clk;

  function automatic logic [7:0] abyte(input logic [15:0] a);
    logic [15:0] t;
    t = (a * 16'd29) ^ (a >> 3) ^ 16'h005A;
    return t[7:0];
  endfunction

  assign arr_bytes = {abyte(addr + 16'd3), abyte(addr + 16'd2),
                      abyte(addr + 16'd1), abyte(addr)};

  flrd_read_mux u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_en(rd_en),
    .rd_addr_lo(addr[7:0]), .rd_size(rd_size), .arr_bytes(arr_bytes),
    .prog_load(prog_load), .prog_d7(prog_d7), .erase_start(erase_start),
    .op_done(op_done), .rd_valid(v_le), .rd_data(d_le)
  );

  flrd_read_mux #(.BUS_BYTES(4), .BIG_ENDIAN(1'b1)) u_dut_be (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_en(rd_en),
    .rd_addr_lo(addr[7:0]), .rd_size(rd_size), .arr_bytes(arr_bytes),
    .prog_load(prog_load), .prog_d7(prog_d7), .erase_start(erase_start),
    .op_done(op_done), .rd_valid(v_be), .rd_data(d_be)
  );

  // query table restated with literal values for the default geometry
  function automatic logic [7:0] exp_query(input logic [7:0] o);
    case (o)
      8'h10: return "Q";  8'h11: return "R";  8'h12: return "Y";
      8'h13: return 8'h02; 8'h15: return 8'h31;
      8'h1B: return 8'h27; 8'h1C: return 8'h36; 8'h1F: return 8'h07;
      8'h21: return 8'h09; 8'h22: return 8'h0C; 8'h23: return 8'h01;
      8'h25: return 8'h0A; 8'h26: return 8'h0D;
      8'h27: return 8'd22; 8'h28: return 8'h02; 8'h2C: return 8'h01;
      8'h2D: return 8'd63; 8'h30: return 8'h01;
      8'h31: return "P";  8'h32: return "R";  8'h33: return "I";
      8'h34: return "1";  8'h35: return "0";
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] exp_array(input logic [15:0] a, input logic [1:0] sz,
                                            input bit be);
    logic [7:0] b0, b1, b2, b3;
    b0 = abyte(a); b1 = abyte(a + 16'd1); b2 = abyte(a + 16'd2); b3 = abyte(a + 16'd3);
    if (sz == 2'd0) return {24'h0, b0};
    if (sz == 2'd1) return be ? {16'h0, b0, b1} : {16'h0, b1, b0};
    return be ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] m, input logic [15:0] a,
                                           input logic [1:0] sz, input bit be,
                                           input int sh, input logic [7:0] st);
    logic [7:0] o;
    o = a[7:0] >> sh;
    case (m)
      3'd2: begin
        if (o == 8'h00) return 32'h0001;
        if (o == 8'h01) return 32'h227E;
        if (o == 8'h02) return 32'h0;
        if (o == 8'h0E) return 32'h2210;
        return exp_array(a, sz, be);
      end
      3'd3: return {24'h0, st};
      3'd4: return (o < 8'h52) ? {24'h0, exp_query(o)} : 32'h0;
      default: return exp_array(a, sz, be);
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one read on both instances; result checked one cycle after the request
  task automatic do_read(input string req, input logic [2:0] m, input logic [15:0] a,
                         input logic [1:0] sz);
    logic [31:0] e_le, e_be;
    @(negedge clk);
    mode = m; addr = a; rd_size = sz; rd_en = 1'b1;
    e_le = exp_read(m, a, sz, 1'b0, 1, exp_st);
    e_be = exp_read(m, a, sz, 1'b1, 2, exp_st);
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    check({req, " R2 valid"}, {31'h0, v_le & v_be}, 32'h1);
    check(req, d_le, e_le);
    check({req, " (32-bit big-endian)"}, d_be, e_be);
    if (m == 3'd3) exp_st = exp_st ^ 8'h40;
  endtask

  task automatic pulse(input int kind, input logic d7);
    @(negedge clk);
    case (kind)
      0: erase_start = 1'b1;
      1: begin prog_load = 1'b1; prog_d7 = d7; end
      default: op_done = 1'b1;
    endcase
    @(negedge clk);
    erase_start = 1'b0; prog_load = 1'b0; op_done = 1'b0;
    case (kind)
      0: exp_st = 8'h00;
      1: exp_st = {~d7, 7'h7F};
      default: exp_st = exp_st ^ 8'h80;
    endcase
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset valid", {31'h0, v_le}, 32'h0);
    check("R1 reset data", d_le, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    do_read("R1 status after reset", 3'd3, 16'h0000, 2'd0);

    // R3 array packing and unknown modes
    do_read("R3 byte read", 3'd0, 16'h0123, 2'd0);
    do_read("R3 half read", 3'd0, 16'h0456, 2'd1);
    do_read("R3 word read", 3'd1, 16'h0789, 2'd2);
    do_read("R3 unknown mode", 3'd6, 16'h0ABC, 2'd3);
    // R4 offset scaling: low bit dropped on the 16-bit instance
    do_read("R4 scaled offset", 3'd4, 16'h0021, 2'd0);
    // R5 and R6 identification
    do_read("R5 manufacturer", 3'd2, 16'h0000, 2'd1);
    do_read("R5 device", 3'd2, 16'h0002, 2'd1);
    do_read("R5 unprotected", 3'd2, 16'h0004, 2'd1);
    do_read("R6 ext id0", 3'd2, 16'h001C, 2'd1);
    do_read("R6 ext id1 all ones", 3'd2, 16'h001E, 2'd1);
    do_read("R6 other offset", 3'd2, 16'h000A, 2'd1);
    // R10 signature and size, R9 tail
    do_read("R10 Q", 3'd4, 16'h0020, 2'd0);
    do_read("R10 R", 3'd4, 16'h0022, 2'd0);
    do_read("R10 Y", 3'd4, 16'h0024, 2'd0);
    do_read("R10 size", 3'd4, 16'h004E, 2'd0);
    do_read("R10 sectors", 3'd4, 16'h005A, 2'd0);
    do_read("R9 table end", 3'd4, 16'h00A4, 2'd0);
    do_read("R9 far offset", 3'd4, 16'h00FE, 2'd0);
    // R7 and R8 status behaviour
    pulse(0, 1'b0);
    do_read("R7 toggle first", 3'd3, 16'h0000, 2'd0);
    do_read("R7 toggle second", 3'd3, 16'h0000, 2'd0);
    do_read("R7 toggle third", 3'd3, 16'h0000, 2'd0);
    pulse(1, 1'b1);
    do_read("R8 program d7=1", 3'd3, 16'h0000, 2'd0);
    pulse(1, 1'b0);
    do_read("R8 program d7=0", 3'd3, 16'h0000, 2'd0);
    pulse(2, 1'b0);
    do_read("R8 op done", 3'd3, 16'h0000, 2'd0);
    do_read("R11 non-status read", 3'd0, 16'h0010, 2'd2);
    do_read("R11 status unchanged", 3'd3, 16'h0000, 2'd0);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int kind;
      logic [7:0] lo;
      logic [2:0] m;
      kind = int'($urandom % 10);
      m = 3'($urandom % 8);
      if (kind == 0) begin
        pulse(int'($urandom % 3), 1'($urandom));
      end else begin
        lo = 8'($urandom);
        if (m == 3'd2 && kind < 6) begin
          case ($urandom % 5)
            0: lo = 8'h00; 1: lo = 8'h02; 2: lo = 8'h04;
            3: lo = 8'h1C; default: lo = 8'h1E;
          endcase
        end
        do_read("R3/R5/R6/R7/R9/R11 random", m, {8'($urandom), lo}, 2'($urandom));
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule